// File: doc/BRIEF.md
# Synchronising Register File Scheduler

This block keeps a register file in which every register also works as a synchronisation point between hardware threads. Each register is in one of three states: empty, full, or waiting. A circular queue of active thread IDs feeds the issue stage. Only the thread at the head of the queue may issue. When it issues an instruction that reads a full register, the value is returned and the thread goes back to the tail of the queue, unless the instruction is its last. When the register is not full, the thread leaves the queue and is parked on that register.

Parked threads form a linked list per register, in the order they were parked. A write to a waiting register stores the value and marks the register full. The whole list then moves to a wake chain. The chain returns one thread per cycle to the tail of the active queue, and each woken thread then issues its blocked instruction again. Results come back on two write-back ports. The fixed-delay port has priority over the variable-delay port (used for loads, for example).

Creating a thread puts it in the queue and clears a small window of registers that form its context. An idle output is high whenever no thread is active or waiting to be woken, so that the core can be powered down.

Top module: `srf_sched`

## Requirements
- R1: After reset the queue is empty, `idle` is 1, `head_valid` is 0, `vwb_ready` is 1, and every register is empty, so a first read of any register misses.
- R2: A create appends `crt_tid` to the tail of the active queue, and the thread appears on `head_tid` one cycle later if the queue was empty. The queue holds up to 16 threads and gives them out in the order they were appended.
- R3: An issue is accepted only when `iss_valid` and `head_valid` are both 1, and it always belongs to `head_tid`. An `iss_valid` while `head_valid` is 0 produces no response and has no effect.
- R4: An accepted issue gives, one cycle later, `rsp_valid`=1 and `rsp_tid` equal to the issuing thread. When the register is full, `rsp_hit`=1, `rsp_data` carries the register value, and the thread goes back to the queue tail, unless `iss_retire` is 1, in which case it leaves the queue.
- R5: An accepted issue to an empty or waiting register answers with `rsp_hit`=0, removes the thread from the queue and parks it on that register, which then becomes waiting.
- R6: A write to a waiting register stores the data, marks the register full and wakes its parked threads in the order they were parked. They are appended to the queue tail one per cycle, and the first one is appended on the edge after the write.
- R7: A write to a full register replaces its value, leaves it full and wakes no thread.
- R8: When both write-back ports are valid in the same cycle, the fixed-delay port is taken. `vwb_ready` is 0 whenever `fwb_valid` is 1, and the variable-delay write takes effect only in a cycle where `vwb_ready` is 1.
- R9: An issue and a write to the same register in the same cycle count as a hit. The response carries the data being written, and the thread is not parked.
- R10: A create marks empty the CTX_REGS registers starting at `crt_base`, wrapping modulo the register count. A waiting register in that window keeps its parked threads, and a write in the same cycle to a register in the window takes precedence.
- R11: `idle` is 1 exactly when the active queue is empty and no woken thread is still waiting to be appended to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| crt_valid | input | 1 | Create a thread this cycle |
| crt_tid | input | 4 | ID of the thread to create |
| crt_base | input | 5 | First register of the context window to clear |
| head_valid | output | 1 | Active queue is not empty |
| head_tid | output | 4 | Thread at the head of the active queue |
| iss_valid | input | 1 | Head thread issues an instruction |
| iss_reg | input | 5 | Source register read by that instruction |
| iss_retire | input | 1 | Instruction is the thread's last; do not requeue on a hit |
| rsp_valid | output | 1 | Issue response valid |
| rsp_tid | output | 4 | Thread the response belongs to |
| rsp_hit | output | 1 | 1 = operand forwarded, 0 = thread parked |
| rsp_data | output | 32 | Forwarded operand |
| fwb_valid | input | 1 | Fixed-delay write-back valid |
| fwb_reg | input | 5 | Fixed-delay destination register |
| fwb_data | input | 32 | Fixed-delay result |
| vwb_valid | input | 1 | Variable-delay write-back valid |
| vwb_reg | input | 5 | Variable-delay destination register |
| vwb_data | input | 32 | Variable-delay result |
| vwb_ready | output | 1 | Variable-delay write accepted this cycle |
| idle | output | 1 | No active or pending thread |

## Verification
The hardest case to reach is a register that holds a list of several parked threads, with other operations landing on it while the list exists. A create that clears the window containing that register must leave the list intact, and a later write must release the threads one per cycle and in the order they were parked. From the ports, this needs two threads to miss on the same register in turn, with a create for another thread in between whose window covers that register. The bench then waits through the wake cycles and reads the queue order back by issuing each thread and checking `head_tid`. A second case that is hard to reach is an issue and a write-back to the same register in the same cycle. The bench reaches it by holding the fixed-delay write on the same edge as the issue.

// File: rtl/srf_pkg.sv
package srf_pkg;

  typedef enum logic [1:0] {
    RS_EMPTY = 2'd0,
    RS_FULL  = 2'd1,
    RS_WAIT  = 2'd2
  } rstate_e;

  // distance of r from base going upward around a ring of nregs entries
  function automatic int unsigned ring_dist(input int unsigned r, input int unsigned base,
                                            input int unsigned nregs);
    return (r + nregs - base) % nregs;
  endfunction

  // true when register r lies in the span-wide window that starts at base
  function automatic logic in_window(input int unsigned r, input int unsigned base,
                                     input int unsigned span, input int unsigned nregs);
    return ring_dist(r, base, nregs) < span;
  endfunction

endpackage

// File: rtl/srf_regs.sv
module srf_regs
  import srf_pkg::*;
#(
  parameter int NREGS    = 32,
  parameter int NTHREADS = 16,
  parameter int DW       = 32,
  parameter int CTX_REGS = 4,
  localparam int RW = $clog2(NREGS),
  localparam int TW = $clog2(NTHREADS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_valid,
  input  logic [RW-1:0] clr_base,
  input  logic          wr_valid,
  input  logic [RW-1:0] wr_reg,
  input  logic [DW-1:0] wr_data,
  input  logic          sus_valid,
  input  logic [RW-1:0] sus_reg,
  input  logic [TW-1:0] sus_tid,
  input  logic [RW-1:0] rd_reg,
  output rstate_e       rd_state,
  output logic [DW-1:0] rd_data,
  output logic [TW-1:0] rd_tail,
  output logic          wake_ev,
  output logic [TW-1:0] wake_head,
  output logic [TW-1:0] wake_tail
);

  rstate_e       st_q [NREGS];
  logic [DW-1:0] data_q [NREGS];
  logic [TW-1:0] hd_q [NREGS];
  logic [TW-1:0] tl_q [NREGS];

  assign rd_state  = st_q[rd_reg];
  assign rd_data   = data_q[rd_reg];
  assign rd_tail   = tl_q[rd_reg];
  assign wake_ev   = wr_valid && (st_q[wr_reg] == RS_WAIT);
  assign wake_head = hd_q[wr_reg];
  assign wake_tail = tl_q[wr_reg];

  // order of effect: context clear, then write, then parking
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREGS; i++) begin
        st_q[i]   <= RS_EMPTY;
        data_q[i] <= '0;
        hd_q[i]   <= '0;
        tl_q[i]   <= '0;
      end
    end else begin
      for (int i = 0; i < NREGS; i++) begin
        if (clr_valid && in_window(i, 32'(clr_base), CTX_REGS, NREGS) && st_q[i] != RS_WAIT)
          st_q[i] <= RS_EMPTY;
        if (wr_valid && wr_reg == RW'(i)) begin
          st_q[i]   <= RS_FULL;
          data_q[i] <= wr_data;
        end
        if (sus_valid && sus_reg == RW'(i)) begin
          st_q[i] <= RS_WAIT;
          tl_q[i] <= sus_tid;
          if (st_q[i] != RS_WAIT) hd_q[i] <= sus_tid;
        end
      end
    end
  end

  // R7: every accepted write leaves its register full
  a_r7_write_full: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |=> st_q[$past(wr_reg)] == RS_FULL);

  // R5: a parked thread becomes the tail of a waiting register
  a_r5_park_wait: assert property (@(posedge clk) disable iff (!rst_n)
    sus_valid |=> (st_q[$past(sus_reg)] == RS_WAIT) && (tl_q[$past(sus_reg)] == $past(sus_tid)));

  // R9: the issue logic never parks on a register written in the same cycle
  a_r9_no_park_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    (sus_valid && wr_valid) |-> sus_reg != wr_reg);

endmodule

// File: rtl/srf_wake.sv
module srf_wake #(
  parameter int NTHREADS = 16,
  localparam int TW = $clog2(NTHREADS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          link_valid,
  input  logic [TW-1:0] link_from,
  input  logic [TW-1:0] link_to,
  input  logic          cat_valid,
  input  logic [TW-1:0] cat_head,
  input  logic [TW-1:0] cat_tail,
  output logic          pop_valid,
  output logic [TW-1:0] pop_tid,
  output logic          pend
);

  logic [TW-1:0] next_q [NTHREADS];
  logic          wk_valid_q;
  logic [TW-1:0] wk_head_q, wk_tail_q;
  logic          rem_valid;
  logic [TW-1:0] rem_head;

  assign pop_valid = wk_valid_q;
  assign pop_tid   = wk_head_q;
  assign pend      = wk_valid_q;
  assign rem_valid = wk_valid_q && (wk_head_q != wk_tail_q);
  assign rem_head  = next_q[wk_head_q];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NTHREADS; i++) next_q[i] <= '0;
      wk_valid_q <= 1'b0;
      wk_head_q  <= '0;
      wk_tail_q  <= '0;
    end else begin
      if (link_valid) next_q[link_from] <= link_to;
      if (cat_valid) begin
        if (rem_valid) next_q[wk_tail_q] <= cat_head;
        wk_valid_q <= 1'b1;
        wk_head_q  <= rem_valid ? rem_head : cat_head;
        wk_tail_q  <= cat_tail;
      end else begin
        wk_valid_q <= rem_valid;
        wk_head_q  <= rem_head;
      end
    end
  end

  // R6: a released list is always pending on the next cycle
  a_r6_cat_pending: assert property (@(posedge clk) disable iff (!rst_n)
    cat_valid |=> wk_valid_q);

  // R6: parking and release never rewrite the same link
  a_r6_link_distinct: assert property (@(posedge clk) disable iff (!rst_n)
    (link_valid && cat_valid && rem_valid) |-> link_from != wk_tail_q);

endmodule

// File: rtl/srf_actq.sv
module srf_actq #(
  parameter int DEPTH = 16,
  parameter int NPUSH = 3,
  localparam int TW = $clog2(DEPTH),
  localparam int PW = $clog2(DEPTH)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NPUSH-1:0]          push_v,
  input  logic [NPUSH-1:0][TW-1:0]  push_tid,
  input  logic                      pop,
  output logic                      head_valid,
  output logic [TW-1:0]             head_tid
);

  logic [TW-1:0] mem_q [DEPTH];
  logic [PW-1:0] rd_q, wr_q;
  logic [PW:0]   cnt_q;
  logic [PW:0]   off [NPUSH];
  logic [PW:0]   npush;

  // slot for a push that sits off places behind the tail (DEPTH is a power of two)
  function automatic logic [PW-1:0] slot(input logic [PW-1:0] base, input logic [PW:0] k);
    return base + k[PW-1:0];
  endfunction

  always_comb begin
    npush = '0;
    for (int j = 0; j < NPUSH; j++) begin
      off[j] = npush;
      npush  = npush + {{PW{1'b0}}, push_v[j]};
    end
  end

  assign head_valid = cnt_q != '0;
  assign head_tid   = mem_q[rd_q];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
    end else begin
      for (int j = 0; j < NPUSH; j++)
        if (push_v[j]) mem_q[slot(wr_q, off[j])] <= push_tid[j];
      wr_q  <= slot(wr_q, npush);
      rd_q  <= rd_q + PW'(pop);
      cnt_q <= cnt_q + npush - {{PW{1'b0}}, pop};
    end
  end

  // R2: the queue never holds more than DEPTH threads
  a_r2_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= (PW+1)'(DEPTH));

  // R3: a thread leaves only from a non-empty queue
  a_r3_pop_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> cnt_q != '0);

endmodule

// File: rtl/srf_sched.sv
module srf_sched
  import srf_pkg::*;
#(
  parameter int NTHREADS = 16,
  parameter int NREGS    = 32,
  parameter int DW       = 32,
  parameter int CTX_REGS = 4,
  localparam int TW = $clog2(NTHREADS),
  localparam int RW = $clog2(NREGS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          crt_valid,
  input  logic [TW-1:0] crt_tid,
  input  logic [RW-1:0] crt_base,
  output logic          head_valid,
  output logic [TW-1:0] head_tid,
  input  logic          iss_valid,
  input  logic [RW-1:0] iss_reg,
  input  logic          iss_retire,
  output logic          rsp_valid,
  output logic [TW-1:0] rsp_tid,
  output logic          rsp_hit,
  output logic [DW-1:0] rsp_data,
  input  logic          fwb_valid,
  input  logic [RW-1:0] fwb_reg,
  input  logic [DW-1:0] fwb_data,
  input  logic          vwb_valid,
  input  logic [RW-1:0] vwb_reg,
  input  logic [DW-1:0] vwb_data,
  output logic          vwb_ready,
  output logic          idle
);

  // named internal events
  logic          wr_valid;
  logic [RW-1:0] wr_reg;
  logic [DW-1:0] wr_data;
  logic          fire, bypass, hit_ev, park_ev, link_ev, requeue_ev;
  rstate_e       rd_state;
  logic [DW-1:0] rd_data;
  logic [TW-1:0] rd_tail;
  logic          wake_ev;
  logic [TW-1:0] wake_head, wake_tail;
  logic          wk_pop, wk_pend;
  logic [TW-1:0] wk_tid;
  logic [2:0]         push_v;
  logic [2:0][TW-1:0] push_tid;

  // write-back arbitration: fixed-delay port first
  assign vwb_ready = !fwb_valid;
  assign wr_valid  = fwb_valid || vwb_valid;
  assign wr_reg    = fwb_valid ? fwb_reg  : vwb_reg;
  assign wr_data   = fwb_valid ? fwb_data : vwb_data;

  assign fire       = iss_valid && head_valid;
  assign bypass     = wr_valid && (wr_reg == iss_reg);
  assign hit_ev     = fire && ((rd_state == RS_FULL) || bypass);
  assign park_ev    = fire && !hit_ev;
  assign link_ev    = park_ev && (rd_state == RS_WAIT);
  assign requeue_ev = hit_ev && !iss_retire;

  srf_regs #(.NREGS(NREGS), .NTHREADS(NTHREADS), .DW(DW), .CTX_REGS(CTX_REGS)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .clr_valid(crt_valid), .clr_base(crt_base),
    .wr_valid(wr_valid), .wr_reg(wr_reg), .wr_data(wr_data),
    .sus_valid(park_ev), .sus_reg(iss_reg), .sus_tid(head_tid),
    .rd_reg(iss_reg), .rd_state(rd_state), .rd_data(rd_data), .rd_tail(rd_tail),
    .wake_ev(wake_ev), .wake_head(wake_head), .wake_tail(wake_tail)
  );

  srf_wake #(.NTHREADS(NTHREADS)) u_wake (
    .clk(clk), .rst_n(rst_n),
    .link_valid(link_ev), .link_from(rd_tail), .link_to(head_tid),
    .cat_valid(wake_ev), .cat_head(wake_head), .cat_tail(wake_tail),
    .pop_valid(wk_pop), .pop_tid(wk_tid), .pend(wk_pend)
  );

  // push order at the tail: requeued issuer, woken thread, new thread
  assign push_v   = {crt_valid, wk_pop, requeue_ev};
  assign push_tid = {crt_tid, wk_tid, head_tid};

  srf_actq #(.DEPTH(NTHREADS), .NPUSH(3)) u_actq (
    .clk(clk), .rst_n(rst_n),
    .push_v(push_v), .push_tid(push_tid), .pop(fire),
    .head_valid(head_valid), .head_tid(head_tid)
  );

  assign idle = !head_valid && !wk_pend;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_tid   <= '0;
      rsp_hit   <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= fire;
      if (fire) begin
        rsp_tid  <= head_tid;
        rsp_hit  <= hit_ev;
        rsp_data <= bypass ? wr_data : rd_data;
      end
    end
  end

  // R11: an idle block has nothing to wake on the next edge
  a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && !crt_valid && !wake_ev) |=> idle);

  // R9: a same-cycle write to the issued register is forwarded
  a_r9_bypass_data: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && bypass) |=> rsp_hit && rsp_data == $past(wr_data));

endmodule

// File: tb/sim_srf_sched.sv
module sim_srf_sched;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        crt_valid;
  logic [3:0]  crt_tid;
  logic [4:0]  crt_base;
  logic        head_valid;
  logic [3:0]  head_tid;
  logic        iss_valid;
  logic [4:0]  iss_reg;
  logic        iss_retire;
  logic        rsp_valid;
  logic [3:0]  rsp_tid;
  logic        rsp_hit;
  logic [31:0] rsp_data;
  logic        fwb_valid;
  logic [4:0]  fwb_reg;
  logic [31:0] fwb_data;
  logic        vwb_valid;
  logic [4:0]  vwb_reg;
  logic [31:0] vwb_data;
  logic        vwb_ready;
  logic        idle;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  srf_sched u0 (
    .clk(clk), .rst_n(rst_n),
    .crt_valid(crt_valid), .crt_tid(crt_tid), .crt_base(crt_base),
    .head_valid(head_valid), .head_tid(head_tid),
    .iss_valid(iss_valid), .iss_reg(iss_reg), .iss_retire(iss_retire),
    .rsp_valid(rsp_valid), .rsp_tid(rsp_tid), .rsp_hit(rsp_hit), .rsp_data(rsp_data),
    .fwb_valid(fwb_valid), .fwb_reg(fwb_reg), .fwb_data(fwb_data),
    .vwb_valid(vwb_valid), .vwb_reg(vwb_reg), .vwb_data(vwb_data),
    .vwb_ready(vwb_ready), .idle(idle)
  );

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic create(input logic [3:0] t, input logic [4:0] b);
    crt_valid = 1'b1; crt_tid = t; crt_base = b;
    tick();
    crt_valid = 1'b0;
  endtask

  task automatic wr_fixed(input logic [4:0] r, input logic [31:0] d);
    fwb_valid = 1'b1; fwb_reg = r; fwb_data = d;
    tick();
    fwb_valid = 1'b0;
  endtask

  task automatic issue(input logic [4:0] r, input logic ret, input logic [3:0] etid,
                       input logic ehit, input logic [31:0] edata, input string rq);
    chk(rq, head_valid, 1);
    chk(rq, head_tid, etid);
    iss_valid = 1'b1; iss_reg = r; iss_retire = ret;
    tick();
    iss_valid = 1'b0; iss_retire = 1'b0;
    chk(rq, rsp_valid, 1);
    chk(rq, rsp_tid, etid);
    chk(rq, rsp_hit, ehit);
    if (ehit) chk(rq, rsp_data, edata);
  endtask

  task automatic t_reset();
    chk("R1 idle", idle, 1);
    chk("R1 head_valid", head_valid, 0);
    chk("R1 vwb_ready", vwb_ready, 1);
  endtask

  task automatic t_park_wake();
    create(4'd3, 5'd0);
    create(4'd5, 5'd4);
    chk("R2 head", head_tid, 3);
    chk("R11 busy", idle, 0);
    issue(5'd2, 1'b0, 4'd3, 1'b0, 32'h0, "R1 R5 miss first");
    issue(5'd2, 1'b0, 4'd5, 1'b0, 32'h0, "R5 miss second");
    chk("R11 idle all parked", idle, 1);
    wr_fixed(5'd2, 32'hAA);
    chk("R11 wake pending not idle", idle, 0);
    chk("R6 not yet in queue", head_valid, 0);
    tick();
    chk("R6 first waiter back", head_valid, 1);
    chk("R6 first waiter id", head_tid, 3);
    tick();
    issue(5'd2, 1'b0, 4'd3, 1'b1, 32'hAA, "R4 R6 hit after wake");
    issue(5'd2, 1'b1, 4'd5, 1'b1, 32'hAA, "R4 R6 second waiter retire");
    chk("R4 requeued thread at head", head_tid, 3);
  endtask

  task automatic t_overwrite();
    wr_fixed(5'd2, 32'h55);
    issue(5'd2, 1'b0, 4'd3, 1'b1, 32'h55, "R7 overwrite value");
    issue(5'd2, 1'b1, 4'd3, 1'b1, 32'h55, "R7 still full");
    chk("R7 no spurious wake", idle, 1);
  endtask

  task automatic t_ignore();
    iss_valid = 1'b1; iss_reg = 5'd2;
    tick();
    iss_valid = 1'b0;
    chk("R3 no response on empty queue", rsp_valid, 0);
    chk("R3 still idle", idle, 1);
  endtask

  task automatic t_ports();
    create(4'd7, 5'd8);
    fwb_valid = 1'b1; fwb_reg = 5'd9;  fwb_data = 32'h11;
    vwb_valid = 1'b1; vwb_reg = 5'd10; vwb_data = 32'h22;
    #1;
    chk("R8 variable port held off", vwb_ready, 0);
    tick();
    fwb_valid = 1'b0;
    #1;
    chk("R8 variable port free", vwb_ready, 1);
    tick();
    vwb_valid = 1'b0;
    issue(5'd10, 1'b0, 4'd7, 1'b1, 32'h22, "R8 variable data");
    issue(5'd9,  1'b0, 4'd7, 1'b1, 32'h11, "R8 fixed data");
  endtask

  task automatic t_bypass();
    fwb_valid = 1'b1; fwb_reg = 5'd11; fwb_data = 32'h33;
    issue(5'd11, 1'b0, 4'd7, 1'b1, 32'h33, "R9 same-cycle write forwarded");
    fwb_valid = 1'b0;
    chk("R9 thread requeued", head_tid, 7);
  endtask

  task automatic t_clear();
    create(4'd8, 5'd9);
    issue(5'd9, 1'b0, 4'd7, 1'b0, 32'h0, "R10 cleared register misses");
    create(4'd9, 5'd8);
    issue(5'd9, 1'b0, 4'd8, 1'b0, 32'h0, "R6 second waiter parked");
    wr_fixed(5'd9, 32'h44);
    tick();
    tick();
    issue(5'd9,  1'b1, 4'd9, 1'b1, 32'h44, "R6 creator before woken");
    issue(5'd10, 1'b0, 4'd7, 1'b0, 32'h0,  "R10 R6 waiter kept and woken first");
    issue(5'd9,  1'b1, 4'd8, 1'b1, 32'h44, "R6 woken second");
    chk("R11 idle again", idle, 1);
    wr_fixed(5'd10, 32'h99);
    tick();
    issue(5'd10, 1'b1, 4'd7, 1'b1, 32'h99, "R6 single waiter woken");
  endtask

  task automatic t_wrap();
    wr_fixed(5'd31, 32'h66);
    create(4'd10, 5'd30);
    issue(5'd2,  1'b0, 4'd10, 1'b1, 32'h55, "R10 outside window kept");
    issue(5'd31, 1'b0, 4'd10, 1'b0, 32'h0,  "R10 wrapped window cleared");
    wr_fixed(5'd31, 32'h77);
    tick();
    issue(5'd31, 1'b1, 4'd10, 1'b1, 32'h77, "R6 wrap waiter woken");
    crt_valid = 1'b1; crt_tid = 4'd11; crt_base = 5'd16;
    fwb_valid = 1'b1; fwb_reg = 5'd17; fwb_data = 32'h88;
    tick();
    crt_valid = 1'b0; fwb_valid = 1'b0;
    issue(5'd17, 1'b1, 4'd11, 1'b1, 32'h88, "R10 write beats clear");
  endtask

  task automatic t_capacity();
    for (int t = 0; t < 16; t++) create(4'(t), 5'd20);
    for (int t = 0; t < 16; t++)
      issue(5'd2, 1'b1, 4'(t), 1'b1, 32'h55, "R2 sixteen in order");
    chk("R2 drained", idle, 1);
  endtask

  initial begin
    rst_n = 1'b0;
    crt_valid = 1'b0; crt_tid = '0; crt_base = '0;
    iss_valid = 1'b0; iss_reg = '0; iss_retire = 1'b0;
    fwb_valid = 1'b0; fwb_reg = '0; fwb_data = '0;
    vwb_valid = 1'b0; vwb_reg = '0; vwb_data = '0;
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    t_reset();
    t_park_wake();
    t_overwrite();
    t_ignore();
    t_ports();
    t_bypass();
    t_clear();
    t_wrap();
    t_capacity();
    summary();
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    summary();
  end

endmodule